// File: doc/BRIEF.md
# Sticky Status and Interrupt Controller

This block gathers error events from a data converter into one status word and one interrupt pin. There are five event lines. Two come from the clock-ratio checkers, one for the DAC side and one for the ADC side. Three are overflow flags from the ADC channels. Each event line has an enable bit in a mask. When an unmasked event occurs, its status bit is latched and held until software reads the status word. The read clears every bit at once. A bit whose enable is off reads 0 and never latches.

The interrupt pin is active while any unmasked event is live or any unmasked latched bit is still set. A clock-ratio error that persists therefore keeps the interrupt asserted, even across reads. A two-bit mode input selects how the pin signals. The choices are active high, push-pull active low, and open-drain active low. Open drain is emulated with a data/output-enable pair. The mode is held in a register that resets to active high. The register-access bus and the error detectors themselves sit outside this block.

Top module: `sts_irq_ctrl`

## Requirements
- R1: An unmasked event present in cycle n makes its status bit read 1 from cycle n+1 on. The bit stays 1 until the cycle after a status read.
- R2: With `rd_i` high in cycle n, `rdata_o` in cycle n returns the value held before the read. From cycle n+1 all bits are 0, except bits whose unmasked event was present in cycle n.
- R3: With mask bit i at 0, status bit i reads 0 and does not latch, including while its event is high. Setting the mask bit again later does not expose an earlier event.
- R4: Status layout: bit 4 is the DAC clock-ratio error, bit 3 is the ADC clock-ratio error, and bits 2, 1 and 0 are `ovfl_i[2]`, `ovfl_i[1]` and `ovfl_i[0]`. `mask_i` uses the same bit positions. Bits 7 to 5 always read 0.
- R5: The interrupt is active in any cycle where some unmasked event input is high or some unmasked status bit is set. It stays active across reads while a clock-ratio error persists. It goes inactive after a read once no unmasked event remains.
- R6: An event that arrives in the same cycle as a status read is not lost. Its bit reads 1 after the read.
- R7: Pin encoding by mode. In modes 00 and 11, `irq_oe_o`=1 and `irq_o` equals the active state. In mode 01, `irq_oe_o`=1 and `irq_o` is the inverse of the active state. In mode 10, `irq_o`=0 and `irq_oe_o` equals the active state.
- R8: `irq_mode_i` is registered. The pin follows a new mode from the cycle after it is applied. During and right after reset the pin uses mode 00, whatever value is on `irq_mode_i`.
- R9: Reset (`rst_ni` low) clears every status bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_dac_clk_i | input | 1 | DAC clock-ratio error, level |
| err_adc_clk_i | input | 1 | ADC clock-ratio error, level |
| ovfl_i | input | 3 | ADC overflow flags, bit k is channel k+1 |
| mask_i | input | 5 | Per-event enable, same positions as status bits 4..0 |
| rd_i | input | 1 | Status read strobe, clears on the following edge |
| irq_mode_i | input | 2 | Interrupt pin mode |
| rdata_o | output | 8 | Masked status word |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
A new event and a status read can land in the same cycle. The bench provokes this by raising an overflow flag together with the read strobe. It then checks that the read returns the pre-read word and that the new bit is present in the next cycle, while the other bits are cleared. The bench also holds a clock-ratio error across a read. It checks that the bit re-latches and that the interrupt never drops. A reference model in the bench predicts the word and the pin for every cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    IRQ_HIGH = 2'b00,
    IRQ_LOW  = 2'b01,
    IRQ_OD   = 2'b10,
    IRQ_RSVD = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/sts_sticky_bank.sv
module sts_sticky_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // a disabled bit drops its stored value; a same-cycle event wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[i] <= 1'b0;
      else         sts_q[i] <= en_i[i] & (evt_i[i] | (sts_q[i] & ~clr_i));
    end

    p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && en_i[i]) |=> sts_q[i]);
    p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[i] && en_i[i] && !clr_i) |=> sts_q[i]);
    p_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[i] |=> !sts_q[i]);
    p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt_i[i]) |=> !sts_q[i]);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/sts_irq_pin.sv
module sts_irq_pin
  import sts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       act_i,
  output logic       pin_o,
  output logic       oe_o
);
  irq_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= IRQ_HIGH;
    else         mode_q <= irq_mode_e'(mode_i);
  end

  always_comb begin
    pin_o = act_i;
    oe_o  = 1'b1;
    unique case (mode_q)
      IRQ_LOW:  pin_o = ~act_i;
      IRQ_OD: begin
        pin_o = 1'b0;
        oe_o  = act_i;
      end
      default: ;  // high and reserved share the active-high drive
    endcase
  end

  p_od_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == IRQ_OD) |-> !pin_o);
  p_push_pull_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != IRQ_OD) |-> oe_o);
endmodule

// File: rtl/sts_irq_ctrl.sv
module sts_irq_ctrl #(
  parameter int unsigned NUM_OVFL = 3,
  parameter int unsigned STS_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  err_dac_clk_i,
  input  logic                  err_adc_clk_i,
  input  logic [NUM_OVFL-1:0]   ovfl_i,
  input  logic [NUM_OVFL+1:0]   mask_i,
  input  logic                  rd_i,
  input  logic [1:0]            irq_mode_i,
  output logic [STS_W-1:0]      rdata_o,
  output logic                  irq_o,
  output logic                  irq_oe_o
);
  localparam int unsigned NUM_EVT = NUM_OVFL + 2;

  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] sts;
  logic [NUM_EVT-1:0] live;
  logic               irq_act;

  // DAC clock error above ADC clock error above overflow flags
  assign evt  = {err_dac_clk_i, err_adc_clk_i, ovfl_i};
  assign live = evt & mask_i;

  sts_sticky_bank #(.N(NUM_EVT)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .en_i   (mask_i),
    .clr_i  (rd_i),
    .sts_o  (sts)
  );

  assign rdata_o = STS_W'(sts & mask_i);
  assign irq_act = |live || |(sts & mask_i);

  sts_irq_pin i_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (irq_mode_i),
    .act_i  (irq_act),
    .pin_o  (irq_o),
    .oe_o   (irq_oe_o)
  );

  p_quiet_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && live == '0) |=> (live != '0) || !irq_act);
  p_not_lost_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && live != '0) |=> irq_act);
endmodule

// File: tb/test_sts_irq_ctrl.sv
module test_sts_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       err_dac_clk_i = 1'b0, err_adc_clk_i = 1'b0;
  logic [2:0] ovfl_i = '0;
  logic [4:0] mask_i = '0;
  logic       rd_i = 1'b0;
  logic [1:0] irq_mode_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, irq_oe_o;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] rdata;
    logic       pin;
    logic       oe;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // model state and previous-cycle inputs
  logic [4:0] m_sts = '0, p_ev = '0, p_msk = '0;
  logic       p_rd = 1'b0;
  logic [1:0] m_mode = '0, p_md = '0;

  always #2.5 clk_i = ~clk_i;

  sts_irq_ctrl i_sts_irq_ctrl (
    .clk_i, .rst_ni, .err_dac_clk_i, .err_adc_clk_i, .ovfl_i,
    .mask_i, .rd_i, .irq_mode_i, .rdata_o, .irq_o, .irq_oe_o
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] msk, input logic dac, input logic adc,
                      input logic [2:0] ov, input logic rd, input logic [1:0] md,
                      input string tag);
    item_t it;
    logic [4:0] ev;
    logic a;
    @(posedge clk_i); #1;
    m_sts  = p_msk & (p_ev | (m_sts & {5{~p_rd}}));
    m_mode = p_md;
    mask_i = msk; err_dac_clk_i = dac; err_adc_clk_i = adc;
    ovfl_i = ov; rd_i = rd; irq_mode_i = md;
    ev = {dac, adc, ov};
    a  = |(msk & (ev | m_sts));
    it.rdata = {3'b000, m_sts & msk};
    it.tag   = tag;
    case (m_mode)
      2'b01:   begin it.pin = ~a;   it.oe = 1'b1; end
      2'b10:   begin it.pin = 1'b0; it.oe = a;    end
      default: begin it.pin = a;    it.oe = 1'b1; end
    endcase
    sb_q.push_back(it);
    p_ev = ev; p_msk = msk; p_rd = rd; p_md = md;
  endtask

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.tag, "rdata", rdata_o, it.rdata);
      chk(it.tag, "irq_o", {7'b0, irq_o}, {7'b0, it.pin});
      chk(it.tag, "irq_oe_o", {7'b0, irq_oe_o}, {7'b0, it.oe});
    end
  end

  initial begin
    // reset with noisy inputs: status stays clear, pin in mode 00 (R9, R8)
    mask_i = 5'h1F; err_dac_clk_i = 1'b1; irq_mode_i = 2'b10;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9", "rdata in reset", rdata_o, 8'h00);
    chk("R8", "irq_o mode00 in reset", {7'b0, irq_o}, 8'h01);
    chk("R8", "irq_oe_o in reset", {7'b0, irq_oe_o}, 8'h01);
    mask_i = '0; err_dac_clk_i = 1'b0; irq_mode_i = 2'b00;
    @(negedge clk_i); rst_ni = 1'b1;

    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R9");
    // R1/R4: DAC clock error pulse lands in bit 4 and sticks
    step(5'h1F, 1, 0, 3'b000, 0, 2'b00, "R5");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R1");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R1");
    step(5'h1F, 0, 0, 3'b000, 1, 2'b00, "R2");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R2");
    // R4: layout walk
    step(5'h1F, 0, 1, 3'b000, 0, 2'b00, "R4");
    step(5'h1F, 0, 0, 3'b001, 0, 2'b00, "R4");
    step(5'h1F, 0, 0, 3'b010, 0, 2'b00, "R4");
    step(5'h1F, 0, 0, 3'b100, 0, 2'b00, "R4");
    step(5'h1F, 0, 0, 3'b000, 1, 2'b00, "R4");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R2");
    // R3: masked events do not latch or interrupt
    step(5'h0F, 1, 0, 3'b000, 0, 2'b00, "R3");
    step(5'h0F, 0, 0, 3'b000, 0, 2'b00, "R3");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R3");
    step(5'h1E, 0, 0, 3'b001, 0, 2'b00, "R3");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R3");
    // R6: event with read in same cycle
    step(5'h1F, 0, 0, 3'b001, 0, 2'b00, "R1");
    step(5'h1F, 0, 0, 3'b100, 1, 2'b00, "R6");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R6");
    step(5'h1F, 0, 0, 3'b000, 1, 2'b00, "R2");
    // R5: persisting clock error survives a read
    step(5'h1F, 0, 1, 3'b000, 0, 2'b00, "R5");
    step(5'h1F, 0, 1, 3'b000, 1, 2'b00, "R5");
    step(5'h1F, 0, 1, 3'b000, 0, 2'b00, "R5");
    step(5'h1F, 0, 0, 3'b000, 1, 2'b00, "R5");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R5");
    // R7/R8: modes, inactive then active
    for (int m = 1; m < 4; m++) begin
      step(5'h1F, 0, 0, 3'b000, 0, 2'(m), "R8");
      step(5'h1F, 0, 0, 3'b000, 0, 2'(m), "R7");
      step(5'h1F, 1, 0, 3'b000, 0, 2'(m), "R7");
      step(5'h1F, 0, 0, 3'b000, 0, 2'(m), "R7");
      step(5'h1F, 0, 0, 3'b000, 1, 2'(m), "R7");
      step(5'h1F, 0, 0, 3'b000, 0, 2'(m), "R7");
    end
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R8");
    step(5'h1F, 0, 0, 3'b000, 0, 2'b00, "R8");
    @(negedge clk_i); @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule